// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit operand address for an 8-bit accumulator CPU. Each cycle it takes an addressing-mode code, the prebyte (or zero when there is none), the one or two bytes that follow the opcode, both index registers and the program counter. The program counter value supplied must already point past the current instruction. The block returns the effective address, an address-valid flag and a flag that says the operand is the immediate byte itself.

There are six modes. Two form no address: the implied mode and the immediate mode. The page-zero mode zero-fills the high address byte. The full-address mode takes two bytes, high byte first. The indexed mode adds an unsigned offset to an index register. The branch mode adds a signed offset to the program counter. A single compare on the prebyte selects the second index register. All sums wrap modulo 65536. The logic is combinational. A parameter can add one register stage at the output.

Top module: `eag_unit`

## Requirements
- R1: Mode codes are 0 implied, 1 immediate, 2 page-zero, 3 full, 4 indexed, 5 branch-relative. For code 0 and for the unused codes 6 and 7, `ea` is 0x0000, `ea_valid` is 0 and `imm_sel` is 0.
- R2: In immediate mode (code 1), `imm_sel` is 1, `ea_valid` is 0 and `ea` is 0x0000.
- R3: In page-zero mode (code 2), `ea` equals {0x00, `arg0`} and `ea_valid` is 1.
- R4: In full mode (code 3), `ea` equals {`arg0`, `arg1`}, with `arg0` as the high byte, and `ea_valid` is 1.
- R5: In indexed mode (code 4), `ea` is the selected index register plus `arg0` zero-extended (offset range 0 to 255), modulo 65536.
- R6: In indexed mode, a prebyte of 0x18 selects `idx_y`. Any other prebyte value, including 0x00, 0x1A and 0xCD, selects `idx_x`.
- R7: In branch mode (code 5), `ea` is `pc_next` plus `arg0` sign-extended, modulo 65536 (0x7F gives +127, 0x80 gives -128).
- R8: In modes other than indexed, the prebyte has no effect on any output.
- R9: With OUT_REG=1, the outputs show the result for the inputs sampled at the previous rising clock edge. A clock edge with `rst` high drives all three outputs to zero.
- R10: With OUT_REG=0, the outputs follow the inputs in the same cycle, and `rst` has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Addressing-mode code |
| prebyte | input | 8 | Prebyte of the instruction, 0x00 if none |
| arg0 | input | 8 | First byte after the opcode |
| arg1 | input | 8 | Second byte after the opcode |
| idx_x | input | 16 | First index register |
| idx_y | input | 16 | Second index register |
| pc_next | input | 16 | Program counter already past the instruction |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | High when a memory address is formed |
| imm_sel | output | 1 | High when the operand is the immediate byte |

## Verification
The bench builds two copies of the block with the default 0x18 index prebyte. One has OUT_REG=1 and the other OUT_REG=0. With both copies, the registered latency and reset clearing can be checked on the same stimulus as the same-cycle path. The stimulus includes index 0xFFFF plus an offset, branch offsets 0x7F and 0x80, and a sweep of all 256 branch offsets across the top of the address space.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int EAG_AW = 16;
    localparam int EAG_BW = 8;

    typedef enum logic [2:0] {
        EAG_INH = 3'd0,
        EAG_IMM = 3'd1,
        EAG_DIR = 3'd2,
        EAG_EXT = 3'd3,
        EAG_IDX = 3'd4,
        EAG_REL = 3'd5
    } eag_mode_e;

    typedef struct packed {
        logic [EAG_AW-1:0] addr;
        logic              valid;
        logic              imm;
    } eag_out_t;

    function automatic logic [EAG_AW-1:0] zext_byte(input logic [EAG_BW-1:0] b);
        return {{(EAG_AW-EAG_BW){1'b0}}, b};
    endfunction

    function automatic logic [EAG_AW-1:0] sext_byte(input logic [EAG_BW-1:0] b);
        return {{(EAG_AW-EAG_BW){b[EAG_BW-1]}}, b};
    endfunction
endpackage

// File: rtl/eag_base_sel.sv
module eag_base_sel #(
    parameter int          AW        = 16,
    parameter int          PW        = 8,
    parameter logic [PW-1:0] Y_PREBYTE = 8'h18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] prebyte,
    input  logic [AW-1:0] idx_x,
    input  logic [AW-1:0] idx_y,
    output logic [AW-1:0] base,
    output logic          sel_y
);
    assign sel_y = (prebyte == Y_PREBYTE);
    assign base  = sel_y ? idx_y : idx_x;

    // R6: the alternate prebyte never leaves the first register as base
    assert_ysel_base_R6: assert property (@(posedge clk) disable iff (rst)
        (prebyte == Y_PREBYTE) |-> (base == idx_y));
    assert_xsel_base_R6: assert property (@(posedge clk) disable iff (rst)
        (prebyte != Y_PREBYTE) |-> (base == idx_x));
endmodule

// File: rtl/eag_wrap_add.sv
module eag_wrap_add #(
    parameter int AW     = 16,
    parameter int OW     = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] off,
    output logic [AW-1:0] sum
);
    localparam int EXT = AW - OW;
    logic [AW-1:0] off_ext;
    logic [AW-1:0] diff;

    generate
        if (SIGNED) begin : g_sext
            assign off_ext = {{EXT{off[OW-1]}}, off};
        end else begin : g_zext
            assign off_ext = {{EXT{1'b0}}, off};
        end
    endgenerate

    assign sum  = base + off_ext;
    assign diff = sum - base;

    generate
        if (SIGNED) begin : g_chk_s
            // R7: a non-negative offset moves forward by less than 128
            assert_rel_fwd_R7: assert property (@(posedge clk) disable iff (rst)
                !off[OW-1] |-> (diff < AW'(1 << (OW-1))));
        end else begin : g_chk_u
            // R5: unsigned offset keeps the wrapped distance under 256
            assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
                diff < AW'(1 << OW));
        end
    endgenerate
endmodule

// File: rtl/eag_mode_mux.sv
module eag_mode_mux
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode,
    input  logic [EAG_BW-1:0] arg0,
    input  logic [EAG_BW-1:0] arg1,
    input  logic [EAG_AW-1:0] idx_sum,
    input  logic [EAG_AW-1:0] rel_sum,
    output eag_out_t          res
);
    eag_mode_e m;
    assign m = eag_mode_e'(mode);

    always_comb begin
        res = '0;
        case (m)
            EAG_IMM: res.imm = 1'b1;
            EAG_DIR: begin
                res.addr  = zext_byte(arg0);
                res.valid = 1'b1;
            end
            EAG_EXT: begin
                res.addr  = {arg0, arg1};
                res.valid = 1'b1;
            end
            EAG_IDX: begin
                res.addr  = idx_sum;
                res.valid = 1'b1;
            end
            EAG_REL: begin
                res.addr  = rel_sum;
                res.valid = 1'b1;
            end
            default: res = '0;
        endcase
    end

    // R3: page-zero mode never produces a nonzero high byte
    assert_direct_page0_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2) |-> (res.addr[EAG_AW-1:EAG_BW] == '0 && res.valid));
    // R4: full mode carries the first byte into the high half
    assert_ext_order_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3) |-> (res.addr[EAG_AW-1:EAG_BW] == arg0));
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter bit         OUT_REG   = 1'b1,
    parameter logic [7:0] Y_PREBYTE = 8'h18
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  mode,
    input  logic [7:0]  prebyte,
    input  logic [7:0]  arg0,
    input  logic [7:0]  arg1,
    input  logic [15:0] idx_x,
    input  logic [15:0] idx_y,
    input  logic [15:0] pc_next,
    output logic [15:0] ea,
    output logic        ea_valid,
    output logic        imm_sel
);
    logic [EAG_AW-1:0] base;
    logic              sel_y;
    logic [EAG_AW-1:0] idx_sum;
    logic [EAG_AW-1:0] rel_sum;
    eag_out_t          res;
    eag_out_t          out;

    eag_base_sel #(.AW(EAG_AW), .PW(8), .Y_PREBYTE(Y_PREBYTE)) u_base (
        .clk(clk), .rst(rst), .prebyte(prebyte),
        .idx_x(idx_x), .idx_y(idx_y), .base(base), .sel_y(sel_y)
    );

    eag_wrap_add #(.AW(EAG_AW), .OW(EAG_BW), .SIGNED(1'b0)) u_idx_add (
        .clk(clk), .rst(rst), .base(base), .off(arg0), .sum(idx_sum)
    );

    eag_wrap_add #(.AW(EAG_AW), .OW(EAG_BW), .SIGNED(1'b1)) u_rel_add (
        .clk(clk), .rst(rst), .base(pc_next), .off(arg0), .sum(rel_sum)
    );

    eag_mode_mux u_mux (
        .clk(clk), .rst(rst), .mode(mode), .arg0(arg0), .arg1(arg1),
        .idx_sum(idx_sum), .rel_sum(rel_sum), .res(res)
    );

    generate
        if (OUT_REG) begin : g_reg
            eag_out_t q;
            logic     armed;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q     <= '0;
                    armed <= 1'b0;
                end else begin
                    q     <= res;
                    armed <= 1'b1;
                end
            end
            assign out = q;
            // R9: output is the result captured one edge earlier
            assert_pipe_delay_R9: assert property (@(posedge clk) disable iff (rst)
                armed |-> (out == $past(res)));
        end else begin : g_comb
            assign out = res;
        end
    endgenerate

    assign ea       = out.addr;
    assign ea_valid = out.valid;
    assign imm_sel  = out.imm;

    // R1: no address formed means a zero address
    assert_noaddr_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !ea_valid |-> (ea == '0));
    // R2: the immediate flag excludes a memory address
    assert_imm_novalid_R2: assert property (@(posedge clk) disable iff (rst)
        imm_sel |-> !ea_valid);
    // R6: the second index register is used only for the indexed mode sum
    assert_ysel_used_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_y && mode == 3'd4) |-> (res.addr == idx_y + {8'h00, arg0}));
endmodule

// File: tb/eag_unit_test.sv
module eag_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = '0;
    logic [7:0]  prebyte = '0, arg0 = '0, arg1 = '0;
    logic [15:0] idx_x = '0, idx_y = '0, pc_next = '0;
    logic [15:0] ea_r, ea_c;
    logic        v_r, v_c, i_r, i_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eag_unit #(.OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst), .mode(mode), .prebyte(prebyte), .arg0(arg0), .arg1(arg1),
        .idx_x(idx_x), .idx_y(idx_y), .pc_next(pc_next),
        .ea(ea_r), .ea_valid(v_r), .imm_sel(i_r)
    );

    eag_unit #(.OUT_REG(1'b0)) uut_comb (
        .clk(clk), .rst(rst), .mode(mode), .prebyte(prebyte), .arg0(arg0), .arg1(arg1),
        .idx_x(idx_x), .idx_y(idx_y), .pc_next(pc_next),
        .ea(ea_c), .ea_valid(v_c), .imm_sel(i_c)
    );

    // fields: mode, prebyte, arg0, arg1, x, y, pc, expected ea, valid, imm
    localparam int NV = 18;
    localparam logic [92:0] VEC [NV] = '{
        {3'd0, 8'h00, 8'h55, 8'h66, 16'h1234, 16'h8000, 16'hC000, 16'h0000, 1'b0, 1'b0}, // R1
        {3'd1, 8'h00, 8'h4A, 8'h00, 16'h1234, 16'h8000, 16'hC000, 16'h0000, 1'b0, 1'b1}, // R2
        {3'd2, 8'h00, 8'h5B, 8'h77, 16'h1234, 16'h8000, 16'hC000, 16'h005B, 1'b1, 1'b0}, // R3
        {3'd2, 8'h18, 8'hFF, 8'h00, 16'h1234, 16'h8000, 16'hC000, 16'h00FF, 1'b1, 1'b0}, // R3 R8
        {3'd3, 8'h00, 8'h6D, 8'h00, 16'h1234, 16'h8000, 16'hC000, 16'h6D00, 1'b1, 1'b0}, // R4
        {3'd3, 8'h1A, 8'hFF, 8'hFE, 16'h1234, 16'h8000, 16'hC000, 16'hFFFE, 1'b1, 1'b0}, // R4 R8
        {3'd4, 8'h00, 8'h56, 8'h00, 16'h1234, 16'h8000, 16'hC000, 16'h128A, 1'b1, 1'b0}, // R5
        {3'd4, 8'h18, 8'h56, 8'h00, 16'h1234, 16'h8000, 16'hC000, 16'h8056, 1'b1, 1'b0}, // R6
        {3'd4, 8'h1A, 8'h56, 8'h00, 16'h1234, 16'h8000, 16'hC000, 16'h128A, 1'b1, 1'b0}, // R6
        {3'd4, 8'hCD, 8'h80, 8'h00, 16'h1234, 16'h8000, 16'hC000, 16'h12B4, 1'b1, 1'b0}, // R5 R6
        {3'd4, 8'h00, 8'h01, 8'h00, 16'hFFFF, 16'h0010, 16'hC000, 16'h0000, 1'b1, 1'b0}, // R5
        {3'd4, 8'h18, 8'hFF, 8'h00, 16'h0010, 16'hFFFF, 16'hC000, 16'h00FE, 1'b1, 1'b0}, // R5 R6
        {3'd5, 8'h00, 8'h7F, 8'h00, 16'h1234, 16'h8000, 16'hC000, 16'hC07F, 1'b1, 1'b0}, // R7
        {3'd5, 8'h00, 8'h80, 8'h00, 16'h1234, 16'h8000, 16'hC000, 16'hBF80, 1'b1, 1'b0}, // R7
        {3'd5, 8'h18, 8'hF0, 8'h00, 16'h1234, 16'h8000, 16'h0005, 16'hFFF5, 1'b1, 1'b0}, // R7 R8
        {3'd5, 8'h00, 8'h10, 8'h00, 16'h1234, 16'h8000, 16'hFFF8, 16'h0008, 1'b1, 1'b0}, // R7
        {3'd6, 8'h00, 8'h12, 8'h34, 16'h1234, 16'h8000, 16'hC000, 16'h0000, 1'b0, 1'b0}, // R1
        {3'd7, 8'h18, 8'h12, 8'h34, 16'h1234, 16'h8000, 16'hC000, 16'h0000, 1'b0, 1'b0}  // R1
    };
    localparam string TAG [NV] = '{"R1", "R2", "R3", "R8", "R4", "R8", "R5", "R6", "R6",
                                   "R5", "R5", "R6", "R7", "R7", "R8", "R7", "R1", "R1"};

    task automatic chk(input string tag, input logic [15:0] a, input logic av, input logic ai,
                       input logic [15:0] e, input logic ev, input logic ei);
        checks++;
        if (a !== e || av !== ev || ai !== ei) begin
            errors++;
            $display("FAIL %s: got ea=%h valid=%b imm=%b, expected ea=%h valid=%b imm=%b",
                     tag, a, av, ai, e, ev, ei);
        end
    endtask

    task automatic apply(input logic [92:0] v);
        mode = v[92:90]; prebyte = v[89:82]; arg0 = v[81:74]; arg1 = v[73:66];
        idx_x = v[65:50]; idx_y = v[49:34]; pc_next = v[33:18];
    endtask

    initial begin
        #40000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset with a live address on the inputs: registered copy stays clear (R9)
        apply(VEC[4]);
        repeat (3) @(posedge clk);
        #1 chk("R9 reset", ea_r, v_r, i_r, 16'h0000, 1'b0, 1'b0);
        chk("R10 reset ignored", ea_c, v_c, i_c, 16'h6D00, 1'b1, 1'b0);
        @(negedge clk) rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk) apply(VEC[k]);
            #1 chk({TAG[k], " comb"}, ea_c, v_c, i_c, VEC[k][17:2], VEC[k][1], VEC[k][0]);
            @(posedge clk);
            #1 chk({TAG[k], " reg R9"}, ea_r, v_r, i_r, VEC[k][17:2], VEC[k][1], VEC[k][0]);
        end

        // R9: registered copy holds the previous result until the next edge
        @(negedge clk) apply(VEC[2]);
        @(posedge clk);
        @(negedge clk) apply(VEC[4]);
        #1 chk("R9 latency hold", ea_r, v_r, i_r, 16'h005B, 1'b1, 1'b0);
        chk("R10 same cycle", ea_c, v_c, i_c, 16'h6D00, 1'b1, 1'b0);

        // R9: reset in mid-run clears the registered outputs at the next edge
        rst = 1'b1;
        @(posedge clk);
        #1 chk("R9 mid reset", ea_r, v_r, i_r, 16'h0000, 1'b0, 1'b0);
        chk("R10 mid reset", ea_c, v_c, i_c, 16'h6D00, 1'b1, 1'b0);
        @(negedge clk) rst = 1'b0;

        // R7: every branch offset from a PC near the top of the space
        for (int o = 0; o < 256; o++) begin
            logic [15:0] want;
            @(negedge clk);
            mode = 3'd5; prebyte = 8'h00; arg0 = 8'(o); pc_next = 16'hFFC0;
            want = (o < 128) ? 16'(32'hFFC0 + o) : 16'(32'hFFC0 + o - 256);
            #1 chk("R7 sweep", ea_c, v_c, i_c, want, 1'b1, 1'b0);
        end

        // R8: prebyte sweep in branch mode leaves the address unchanged
        for (int p = 0; p < 256; p += 17) begin
            @(negedge clk);
            mode = 3'd5; prebyte = 8'(p); arg0 = 8'h22; pc_next = 16'h4000;
            #1 chk("R8 prebyte ignored", ea_c, v_c, i_c, 16'h4022, 1'b1, 1'b0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule